// File: doc/BRIEF.md
# Synchronous Serial Video Transmitter

This block is the master end of a three-wire synchronous serial video link. Bytes arrive on a valid/ready handshake and leave one bit at a time on a data pin, most significant bit first. The block derives the serial clock from its system clock through a power-of-two divider and drives a frame signal that marks each datum. Data changes while the serial clock is low and is stable across its rising edge, where the receiver samples it.

A datum is one byte, two bytes, or a line burst that ends with the byte flagged as last. The frame signal works in one of two ways. It can stay high for the whole datum. It can also pulse for one bit slot just ahead of the first data bit. The serial clock is either gated or free-running. In gated mode it toggles only during bit slots that carry a lead marker or data. In free-running mode it never stops. If the source runs dry inside a datum, the block waits at a bit boundary. In gated mode the clock then stays low. Shifting resumes with the next byte and no bit is dropped.

Top module: `sv_serial_tx`

## Requirements
- R1: While reset is asserted and right after it, `sclk`, `sdat` and `sfrm` are all 0.
- R2: One bit slot lasts 2^(`div_sel`+1) system clocks. `sclk` is low for the first half of the slot and high for the second half.
- R3: Each byte is sent most significant bit first. `sdat` changes only in a cycle where `sclk` is 0, so it is stable at every rising edge of `sclk`.
- R4: With `free_run`=0, `sclk` stays 0 whenever no lead or data slot is in progress, idle time included.
- R5: With `free_run`=1, `sclk` toggles continuously with the R2 timing, idle time included.
- R6: With `early_frame`=0, `sfrm` is high at every rising `sclk` edge that carries a data bit of a datum. It falls at the boundary after the last bit of that datum.
- R7: With `early_frame`=1, `sfrm` is high for exactly one bit slot immediately before the first data bit of each datum, and it is 0 during the data bits.
- R8: `size_sel` selects the datum size: 0 is one byte, 1 is two bytes, 2 (and 3) is a line burst that ends with the byte accepted while `in_last`=1.
- R9: If no byte is offered when the next byte of a datum is needed, the block stalls. In gated mode `sclk` stays 0 during the stall. `sfrm` keeps its level. Transmission resumes with the next byte's most significant bit and loses no bit.
- R10: A byte is accepted on a cycle with `in_valid` and `in_ready` both 1. `in_ready` is 1 only at a bit boundary where a new byte is needed, so it stays 0 while a byte is still shifting. The accepted byte's top bit appears on `sdat` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_sel | input | DIV_W | Divider select; bit slot is 2^(div_sel+1) clocks |
| size_sel | input | 2 | Datum size code (R8) |
| early_frame | input | 1 | 1: one-slot frame pulse before data; 0: frame covers the datum |
| free_run | input | 1 | 1: serial clock never stops; 0: gated serial clock |
| in_valid | input | 1 | Source has a byte |
| in_data | input | BYTE_W | Byte to send |
| in_last | input | 1 | Byte ends a line burst |
| in_ready | output | 1 | Block takes the byte this cycle |
| sclk | output | 1 | Serial clock, idles low |
| sdat | output | 1 | Serial data |
| sfrm | output | 1 | Frame signal |

## Verification
The bench uses the default parameters: 8-bit bytes and a 2-bit divider select. With these, all four divide ratios can be driven from the port and their slot length and high time can be measured on a free-running clock. A scoreboard rebuilds bytes and datum lengths from `sdat` at each rising `sclk`. Both frame modes and both clock modes are run against single, double and line-burst datums. A line burst with a mid-datum gap shows that a stall drops no bit.

// File: rtl/svt_pkg.sv
package svt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_STALL = 2'd3
    } svt_state_e;

    localparam logic [1:0] SZ_ONE  = 2'd0;
    localparam logic [1:0] SZ_TWO  = 2'd1;
    localparam logic [1:0] SZ_LINE = 2'd2;
endpackage

// File: rtl/svt_phase.sv
module svt_phase #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             free_run,
    input  logic             active,
    output logic             bnd,
    output logic             sclk
);
    localparam int PH_W = 2 ** DIV_W;
    localparam logic [PH_W-1:0] PH_ONE = PH_W'(1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            sclk;
    } phase_s;

    phase_s ph_q, ph_d;
    logic [PH_W-1:0] half_c, last_c;
    logic            run_c;

    always_comb begin
        half_c = PH_ONE << div_sel;
        last_c = (half_c << 1) - PH_ONE;
        run_c  = free_run || active;
        bnd    = (ph_q.ph == last_c) || !run_c;
        ph_d   = ph_q;
        if (bnd) begin
            ph_d.ph   = '0;
            ph_d.sclk = 1'b0;
        end else begin
            ph_d.ph = ph_q.ph + PH_ONE;
            if (ph_q.ph == half_c - PH_ONE) begin
                ph_d.sclk = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign sclk = ph_q.sclk;

    // R4: the serial clock only rises when a slot was running or the clock is free
    a_r4_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $past(free_run || active));
endmodule

// File: rtl/svt_shreg.sv
module svt_shreg #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              clear,
    input  logic [BYTE_W-1:0] din,
    output logic              bit_o
);
    logic [BYTE_W-1:0] sr_q, sr_d;

    always_comb begin
        sr_d = sr_q;
        if (clear) begin
            sr_d = '0;
        end else if (load) begin
            sr_d = din;
        end else if (shift) begin
            sr_d = {sr_q[BYTE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign bit_o = sr_q[BYTE_W-1];
endmodule

// File: rtl/sv_serial_tx.sv
module sv_serial_tx #(
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [1:0]        size_sel,
    input  logic              early_frame,
    input  logic              free_run,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              sclk,
    output logic              sdat,
    output logic              sfrm
);
    import svt_pkg::*;

    localparam int BIT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

    typedef struct packed {
        svt_state_e       st;
        logic [BIT_W-1:0] bitn;
        logic [1:0]       cnt;
        logic             last;
        logic             frm;
    } ctl_s;

    ctl_s ctl_q, ctl_d;
    logic bnd, active_c, need_more_c;
    logic take_c, shift_c, clear_c;
    logic [1:0] cnt_base_c;

    assign active_c = (ctl_q.st == ST_LEAD) || (ctl_q.st == ST_SHIFT);

    svt_phase #(.DIV_W(DIV_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_sel  (div_sel),
        .free_run (free_run),
        .active   (active_c),
        .bnd      (bnd),
        .sclk     (sclk)
    );

    svt_shreg #(.BYTE_W(BYTE_W)) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (take_c),
        .shift (shift_c),
        .clear (clear_c),
        .din   (in_data),
        .bit_o (sdat)
    );

    always_comb begin
        ctl_d      = ctl_q;
        in_ready   = 1'b0;
        shift_c    = 1'b0;
        clear_c    = 1'b0;
        cnt_base_c = ctl_q.cnt;

        unique case (size_sel)
            SZ_ONE:  need_more_c = 1'b0;
            SZ_TWO:  need_more_c = (ctl_q.cnt == 2'd1);
            default: need_more_c = !ctl_q.last;
        endcase

        unique case (ctl_q.st)
            ST_IDLE: begin
                cnt_base_c = 2'd0;
                in_ready   = bnd && !early_frame;
                if (bnd && in_valid) begin
                    ctl_d.frm = 1'b1;
                    ctl_d.cnt = 2'd0;
                    if (early_frame) begin
                        ctl_d.st = ST_LEAD;
                    end
                end
            end
            ST_LEAD: begin
                in_ready = bnd;
                if (bnd) begin
                    ctl_d.frm = 1'b0;
                    ctl_d.st  = ST_STALL;
                end
            end
            ST_SHIFT: begin
                if (bnd) begin
                    if (ctl_q.bitn != BIT_LAST) begin
                        shift_c    = 1'b1;
                        ctl_d.bitn = ctl_q.bitn + 1'b1;
                    end else if (need_more_c) begin
                        in_ready = 1'b1;
                        ctl_d.st = ST_STALL;
                    end else begin
                        ctl_d.st  = ST_IDLE;
                        ctl_d.frm = 1'b0;
                        clear_c   = 1'b1;
                    end
                end
            end
            default: begin
                in_ready = bnd;
            end
        endcase

        take_c = in_ready && in_valid;
        if (take_c) begin
            ctl_d.st   = ST_SHIFT;
            ctl_d.bitn = '0;
            ctl_d.last = in_last;
            ctl_d.cnt  = (cnt_base_c == 2'd2) ? 2'd2 : cnt_base_c + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, bitn: '0, cnt: 2'd0, last: 1'b0, frm: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sfrm = ctl_q.frm;

    // R3: data only moves while the serial clock is low
    a_r3_sdat_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdat) |-> !sclk);

    // R10: an accepted byte shows its top bit next cycle
    a_r10_take_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (sdat == $past(in_data[BYTE_W-1])));

    // R10: a new slot begins with the clock low
    a_r10_take_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !sclk);

    // R9: a gated stall holds the serial clock low
    a_r9_stall_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_STALL && !free_run) |-> !sclk);
endmodule

// File: tb/test_sv_serial_tx.sv
module test_sv_serial_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic [1:0] size_sel = 2'd0;
    logic       early_frame = 1'b0;
    logic       free_run = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready, sclk, sdat, sfrm;

    always #2 clk = ~clk;

    sv_serial_tx i_sv_serial_tx (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .size_sel(size_sel),
        .early_frame(early_frame), .free_run(free_run), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .sclk(sclk), .sdat(sdat), .sfrm(sfrm)
    );

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_q[$];
    int         len_q[$];
    logic [7:0] tx_buf[16];

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // monitor state
    logic prev_sclk = 1'b0, prev_sfrm = 1'b0;
    bit   in_dat = 1'b0;
    int   bitcnt = 0, cur_len = 0, leads = 0;
    logic [7:0] rx_byte = 8'h00;

    task automatic take_bit();
        logic [7:0] e;
        rx_byte = {rx_byte[6:0], sdat};
        bitcnt++;
        if (bitcnt % 8 == 0) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 byte with nothing expected", rx_byte, -1);
            end else begin
                e = exp_q.pop_front();
                check(rx_byte == e, "R3/R8 received byte", rx_byte, e);
            end
        end
        if (early_frame && bitcnt == cur_len) in_dat = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk && !prev_sclk) begin
                if (!in_dat) begin
                    if (sfrm) begin
                        if (len_q.size() == 0) begin
                            check(1'b0, "R6/R7 frame with no datum", 1, 0);
                        end else begin
                            cur_len = len_q.pop_front();
                            in_dat  = 1'b1;
                            bitcnt  = 0;
                            if (early_frame) leads++;
                            else take_bit();
                        end
                    end
                end else if (early_frame && sfrm) begin
                    check(1'b0, "R7 frame high during data bit", 1, 0);
                end else if (!early_frame && !sfrm) begin
                    check(1'b0, "R6 frame low during data bit", 0, 1);
                end else if (!early_frame && bitcnt >= cur_len) begin
                    check(1'b0, "R6 frame longer than datum", bitcnt + 1, cur_len);
                end else begin
                    take_bit();
                end
            end
            if (!early_frame && prev_sfrm && !sfrm) begin
                check(in_dat && bitcnt == cur_len, "R6 datum length at frame end", bitcnt, cur_len);
                in_dat = 1'b0;
            end
            prev_sclk = sclk;
            prev_sfrm = sfrm;
        end
    end

    task automatic fill(input int n, input int seed);
        for (int i = 0; i < n; i++) tx_buf[i] = 8'((seed * 37 + i * 91) ^ (i << 3));
    endtask

    task automatic send_datum(input int n, input int stall_at, input int stall_cyc);
        bit ok;
        len_q.push_back(n * 8);
        for (int i = 0; i < n; i++) exp_q.push_back(tx_buf[i]);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = tx_buf[i];
            in_last  = (i == n - 1);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            if (i == stall_at) begin
                @(negedge clk);
                in_valid = 1'b0;
                repeat (30) @(negedge clk);
                ok = 1'b1;
                for (int k = 0; k < 10; k++) begin
                    @(negedge clk);
                    if (sclk !== 1'b0 || sfrm !== 1'b1) ok = 1'b0;
                end
                check(ok, "R9 clock low and frame held in stall", sclk, 0);
                repeat (stall_cyc) @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_done();
        while (exp_q.size() != 0 || len_q.size() != 0 || in_dat) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    task automatic measure(output int per, output int hi);
        logic p;
        int   t;
        per = -1; hi = -1; t = 0;
        p = sclk;
        while (!(sclk && !p) && t < 200) begin
            p = sclk;
            @(negedge clk);
            t++;
        end
        if (t >= 200) return;
        per = 0; hi = 1; p = 1'b1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            per++;
            if (sclk && !p) break;
            if (sclk) hi++;
            p = sclk;
        end
    endtask

    task automatic run_tests();
        int per, hi;
        bit ok;
        // R1 reset state
        repeat (5) @(negedge clk);
        check(sclk == 0 && sdat == 0 && sfrm == 0, "R1 outputs in reset", {sclk, sdat, sfrm}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sclk == 0 && sdat == 0 && sfrm == 0, "R1 outputs after reset", {sclk, sdat, sfrm}, 0);

        // R2 / R5 slot timing on a free clock
        free_run = 1'b1;
        for (int d = 0; d < 4; d++) begin
            div_sel = 2'(d);
            repeat (40) @(negedge clk);
            measure(per, hi);
            check(per == (2 << d), "R2/R5 slot length", per, 2 << d);
            check(hi == (1 << d), "R2 high time", hi, 1 << d);
        end
        free_run = 1'b0;
        div_sel  = 2'd0;
        repeat (40) @(negedge clk);
        ok = 1'b1;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (sclk !== 1'b0) ok = 1'b0;
        end
        check(ok, "R4 gated clock quiet when idle", sclk, 0);

        // R3 / R6 / R8 single bytes, frame over datum
        size_sel = 2'd0;
        tx_buf[0] = 8'hA5; send_datum(1, -1, 0);
        tx_buf[0] = 8'h01; send_datum(1, -1, 0);
        tx_buf[0] = 8'h80; send_datum(1, -1, 0);
        wait_done();

        // R8 two-byte datums
        size_sel = 2'd1; div_sel = 2'd1;
        for (int s = 0; s < 3; s++) begin fill(2, s + 1); send_datum(2, -1, 0); end
        wait_done();

        // R8 line bursts
        size_sel = 2'd2; div_sel = 2'd0;
        fill(6, 7); send_datum(6, -1, 0);
        wait_done();
        div_sel = 2'd3;
        fill(3, 9); send_datum(3, -1, 0);
        wait_done();

        // R10 ready stays low while a byte shifts
        size_sel = 2'd0; div_sel = 2'd2;
        tx_buf[0] = 8'h5A; send_datum(1, -1, 0);
        ok = 1'b1;
        for (int k = 0; k < 20; k++) begin
            if (in_ready !== 1'b0) ok = 1'b0;
            @(negedge clk);
        end
        check(ok, "R10 ready low mid byte", in_ready, 0);
        wait_done();

        // R9 stall inside a line burst
        size_sel = 2'd2; div_sel = 2'd0;
        fill(5, 11); send_datum(5, 1, 20);
        wait_done();

        // R7 early frame pulse
        early_frame = 1'b1; div_sel = 2'd1; leads = 0;
        size_sel = 2'd0; tx_buf[0] = 8'hC3; send_datum(1, -1, 0); wait_done();
        size_sel = 2'd1; fill(2, 13); send_datum(2, -1, 0); wait_done();
        size_sel = 2'd2; fill(4, 15); send_datum(4, -1, 0); wait_done();
        check(leads == 3, "R7 one lead slot per datum", leads, 3);

        // R5 free clock with data, both frame modes
        free_run = 1'b1; early_frame = 1'b0; div_sel = 2'd1;
        size_sel = 2'd0; tx_buf[0] = 8'h3C; send_datum(1, -1, 0); wait_done();
        size_sel = 2'd1; fill(2, 17); send_datum(2, -1, 0); wait_done();
        early_frame = 1'b1; size_sel = 2'd2;
        fill(3, 19); send_datum(3, -1, 0); wait_done();
        free_run = 1'b0; early_frame = 1'b0;

        check(exp_q.size() == 0 && len_q.size() == 0, "R8 all datums delivered",
              exp_q.size(), 0);
    endtask

    initial begin
        bit timeout;
        timeout = 1'b0;
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) check(1'b0, "watchdog expired", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule